// File: doc/BRIEF.md
# Two-Dimensional Odd-Parity Configuration Bank

This block holds a small set of volatile configuration words and checks them all the time against a two-dimensional odd-parity code. There are six configuration words and one column-check word, each nine bits wide, plus one status word.

In each configuration word, bit 0 is a row check over bits 8 to 1. The column-check word holds one bit for each bit position. That bit makes its column odd across the six configuration words. Bit 0 of the column-check word covers the six row-check bits.

The block never generates check bits. The host computes every check bit and writes it with the data through a plain address, data and write-enable port. That port stands in for a serial register interface.

Whenever any row or column has an even number of ones, the active-low alert output is driven low. Because reset clears every word to zero, the alert is low straight after reset. It stays low until the host loads a consistent map. Once every check passes, the alert goes high with no other action. A parity failure never alters the stored words.

Top module: `cfgpar_bank`

## Requirements
- R1: An active-low asynchronous reset clears all eight stored words to zero, so alert_n reads 0 straight after reset.
- R2: A write with wr_en=1 to address 0 to 6 stores the full 9-bit wr_data at the clock edge, and rd_data then returns that word while acc_addr selects it.
- R3: A row check applies to each of addresses 0 to 5. The check fails when the nine bits of the word (check bit 0 plus data bits 8 to 1) hold an even number of ones.
- R4: A column check applies to each bit position 0 to 8. The check fails when that bit, taken across the words at addresses 0 to 6, holds an even number of ones. The word at address 6 has no row check of its own.
- R5: Address 7 is a status word. It is stored and read back like the other words, but it takes part in no check, so writing it never changes alert_n.
- R6: alert_n is 0 exactly when at least one row or column check fails, and 1 when all of them pass. It follows the stored words combinationally, so a write that repairs or breaks parity shows on alert_n right after its clock edge.
- R7: Writes to addresses 8 to 15 change no stored word and do not change alert_n. Reads from addresses 8 to 15 return zero.
- R8: A word written with wrong parity is stored exactly as written. The block never corrects or fills in check bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_addr | input | 4 | Word address for both reads and writes |
| wr_en | input | 1 | Write strobe, sampled at the rising edge |
| wr_data | input | 9 | Word to store |
| rd_data | output | 9 | Word at acc_addr (combinational), or zero for an unused address |
| alert_n | output | 1 | Low while any row or column check fails |

## Verification
A write takes effect at the rising edge where wr_en is sampled high. From just after that edge, rd_data and alert_n reflect the new word, with no further register stage.

Reads have no latency: rd_data follows acc_addr within the same cycle. The bench drives inputs on the falling edge and samples outputs one falling edge after each write edge. For reads, it samples shortly after changing acc_addr with no clock edge between.

The bench tracks its own eight-word model and counts ones bit by bit to predict the alert. It checks after every single write, so a one-cycle delay or an early change would show as a mismatch.

// File: rtl/cfgpar_pkg.sv
package cfgpar_pkg;
  // Default geometry of the bank
  localparam int unsigned CFG_WORDS  = 6;   // words carrying a row check
  localparam int unsigned WORD_W     = 9;   // bits per stored word
  localparam int unsigned ADDR_W     = 4;   // access address width
  localparam int unsigned PAR_MAXW   = 16;  // widest vector the helper accepts

  // True when the vector holds an odd number of ones
  function automatic logic odd_ones(input logic [PAR_MAXW-1:0] v);
    return ^v;
  endfunction

  // Check bit that makes the given data odd when appended
  function automatic logic make_odd(input logic [PAR_MAXW-1:0] v);
    return ~(^v);
  endfunction
endpackage

// File: rtl/cfgpar_store.sv
module cfgpar_store
  import cfgpar_pkg::*;
#(
  parameter int unsigned N_CFG = cfgpar_pkg::CFG_WORDS,
  parameter int unsigned W     = cfgpar_pkg::WORD_W,
  parameter int unsigned AW    = cfgpar_pkg::ADDR_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [AW-1:0]           acc_addr,
  input  logic                    wr_en,
  input  logic [W-1:0]            wr_data,
  output logic [W-1:0]            rd_data,
  output logic [(N_CFG+1)*W-1:0]  checked_flat
);
  // words 0..N_CFG-1 configuration, N_CFG column check, N_CFG+1 status
  localparam int unsigned N_WORDS = N_CFG + 2;
  localparam int unsigned IDX_W   = $clog2(N_WORDS);

  logic [W-1:0]     mem [N_WORDS];
  logic             addr_live;
  logic [IDX_W-1:0] idx;

  assign addr_live = (acc_addr < AW'(N_WORDS));
  assign idx       = acc_addr[IDX_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(N_WORDS); i++) mem[i] <= '0;
    end else if (wr_en && addr_live) begin
      mem[idx] <= wr_data;
    end
  end

  assign rd_data = addr_live ? mem[idx] : '0;

  // Hand the checked words (status excluded) to the checkers
  for (genvar g = 0; g <= N_CFG; g++) begin : g_flat
    assign checked_flat[g*W +: W] = mem[g];
  end

  // The status word leaves the bank only through rd_data
endmodule

// File: rtl/cfgpar_row_check.sv
module cfgpar_row_check
  import cfgpar_pkg::*;
#(
  parameter int unsigned N_CFG = cfgpar_pkg::CFG_WORDS,
  parameter int unsigned W     = cfgpar_pkg::WORD_W
) (
  input  logic [(N_CFG+1)*W-1:0] checked_flat,
  output logic [N_CFG-1:0]       row_bad
);
  // Only the configuration words carry a row check
  for (genvar r = 0; r < N_CFG; r++) begin : g_row
    logic [W-1:0] word;
    assign word       = checked_flat[r*W +: W];
    assign row_bad[r] = ~odd_ones(PAR_MAXW'(word));
  end

  // The column-check word is deliberately not examined here
  logic unused_top;
  assign unused_top = ^checked_flat[N_CFG*W +: W];
endmodule

// File: rtl/cfgpar_col_check.sv
module cfgpar_col_check
  import cfgpar_pkg::*;
#(
  parameter int unsigned N_CFG = cfgpar_pkg::CFG_WORDS,
  parameter int unsigned W     = cfgpar_pkg::WORD_W
) (
  input  logic [(N_CFG+1)*W-1:0] checked_flat,
  output logic [W-1:0]           col_bad
);
  localparam int unsigned DEPTH = N_CFG + 1;

  for (genvar c = 0; c < W; c++) begin : g_col
    logic [DEPTH-1:0] slice;
    for (genvar r = 0; r < DEPTH; r++) begin : g_pick
      assign slice[r] = checked_flat[r*W + c];
    end
    assign col_bad[c] = ~odd_ones(PAR_MAXW'(slice));
  end
endmodule

// File: rtl/cfgpar_bank.sv
module cfgpar_bank
  import cfgpar_pkg::*;
#(
  parameter int unsigned N_CFG = cfgpar_pkg::CFG_WORDS,
  parameter int unsigned W     = cfgpar_pkg::WORD_W,
  parameter int unsigned AW    = cfgpar_pkg::ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] acc_addr,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  output logic [W-1:0]  rd_data,
  output logic          alert_n
);
  logic [(N_CFG+1)*W-1:0] checked_flat;
  logic [N_CFG-1:0]       row_bad;
  logic [W-1:0]           col_bad;
  logic                   any_row_bad;
  logic                   any_col_bad;

  cfgpar_store #(.N_CFG(N_CFG), .W(W), .AW(AW)) u_store (
    .clk          (clk),
    .rst_n        (rst_n),
    .acc_addr     (acc_addr),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .rd_data      (rd_data),
    .checked_flat (checked_flat)
  );

  cfgpar_row_check #(.N_CFG(N_CFG), .W(W)) u_rows (
    .checked_flat (checked_flat),
    .row_bad      (row_bad)
  );

  cfgpar_col_check #(.N_CFG(N_CFG), .W(W)) u_cols (
    .checked_flat (checked_flat),
    .col_bad      (col_bad)
  );

  assign any_row_bad = |row_bad;
  assign any_col_bad = |col_bad;
  assign alert_n     = ~(any_row_bad | any_col_bad);
endmodule

// File: rtl/cfgpar_bank_chk.sv
module cfgpar_bank_chk #(
  parameter int unsigned N_CFG = 6,
  parameter int unsigned W     = 9,
  parameter int unsigned AW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] acc_addr,
  input logic          wr_en,
  input logic [W-1:0]  wr_data,
  input logic [W-1:0]  rd_data,
  input logic          alert_n,
  input logic [N_CFG-1:0] row_bad,
  input logic [W-1:0]  col_bad
);
  localparam logic [AW-1:0] STATUS_A = AW'(N_CFG + 1);
  localparam logic [AW-1:0] FIRST_UNUSED = AW'(N_CFG + 2);

  // R1: first sampled edge after reset sees the cleared map
  a_r1_reset_alert: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !alert_n);

  // R2: a stored word reads back while the address holds
  a_r2_write_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && acc_addr < FIRST_UNUSED) |=>
      (acc_addr != $past(acc_addr) || rd_data == $past(wr_data)));

  // R3: a failing row forces the alert
  a_r3_row_alert: assert property (@(posedge clk) disable iff (!rst_n)
    (row_bad != '0) |-> !alert_n);

  // R4: a failing column forces the alert
  a_r4_col_alert: assert property (@(posedge clk) disable iff (!rst_n)
    (col_bad != '0) |-> !alert_n);

  // R5: the status word never moves the alert
  a_r5_status_no_alert: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && acc_addr == STATUS_A) |=> $stable(alert_n));

  // R6: without a write the alert holds
  a_r6_alert_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(alert_n));

  // R7: unused addresses read zero and writes there change nothing
  a_r7_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_addr >= FIRST_UNUSED) |-> (rd_data == '0));
  a_r7_unused_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && acc_addr >= FIRST_UNUSED) |=> $stable(alert_n));

  // R8: contents stay put when nothing writes
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (acc_addr != $past(acc_addr) || $stable(rd_data)));
endmodule

bind cfgpar_bank cfgpar_bank_chk #(.N_CFG(N_CFG), .W(W), .AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .acc_addr (acc_addr),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .rd_data  (rd_data),
  .alert_n  (alert_n),
  .row_bad  (row_bad),
  .col_bad  (col_bad)
);

// File: tb/tb_cfgpar_bank.sv
module tb_cfgpar_bank;
  localparam int NW = 8;

  logic       clk = 0;
  logic       rst_n = 0;
  logic [3:0] acc_addr = '0;
  logic       wr_en = 0;
  logic [8:0] wr_data = '0;
  logic [8:0] rd_data;
  logic       alert_n;

  int checks = 0;
  int failures = 0;
  logic [8:0] model [NW];

  cfgpar_bank dut (.*);

  always #10 clk = ~clk;  // 50 MHz

  // Watchdog
  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  // Vector table: {address, data}; expected results come from the model
  localparam logic [12:0] VEC [12] = '{
    {4'd0, 9'b1_0000_0000}, {4'd1, 9'b0_0000_0011}, {4'd2, 9'b1_1100_1010},
    {4'd6, 9'b1_0101_0101}, {4'd3, 9'b0_0000_0001}, {4'd7, 9'b1_1111_1111},
    {4'd4, 9'b0_1110_0000}, {4'd5, 9'b1_0000_0001}, {4'd9, 9'b1_1111_1111},
    {4'd2, 9'b0_0000_0000}, {4'd15, 9'b0_1010_1011}, {4'd6, 9'b0_0000_0000}
  };

  function automatic int ones(input logic [8:0] v);
    int n = 0;
    for (int b = 0; b < 9; b++) if (v[b]) n++;
    return n;
  endfunction

  function automatic logic model_alert_n();
    for (int r = 0; r < 6; r++) if (ones(model[r]) % 2 == 0) return 1'b0;
    for (int b = 0; b < 9; b++) begin
      int n = 0;
      for (int r = 0; r < 7; r++) if (model[r][b]) n++;
      if (n % 2 == 0) return 1'b0;
    end
    return 1'b1;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [8:0] d);
    @(negedge clk);
    acc_addr = a; wr_data = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
    if (a < 4'd8) model[a] = d;
  endtask

  task automatic rd_check(input logic [3:0] a, input string req);
    acc_addr = a;
    #1;
    chk(rd_data === ((a < 4'd8) ? model[a] : 9'd0), req, rd_data,
        (a < 4'd8) ? model[a] : 9'd0);
  endtask

  task automatic all_check(input string req);
    for (int a = 0; a < 16; a++) rd_check(4'(a), req);
    chk(alert_n === model_alert_n(), req, alert_n, model_alert_n());
  endtask

  // Build a consistent map from eight-bit payloads
  task automatic load_good(input logic [7:0] p0, input logic [7:0] p1);
    logic [8:0] w [6];
    logic [8:0] colw;
    for (int r = 0; r < 6; r++) begin
      logic [7:0] p = (r % 2 == 0) ? (p0 ^ 8'(r)) : (p1 + 8'(r));
      w[r] = {p, ~(^p)};
      wr(4'(r), w[r]);
    end
    for (int b = 0; b < 9; b++) begin
      int n = 0;
      for (int r = 0; r < 6; r++) if (w[r][b]) n++;
      colw[b] = (n % 2 == 0);
    end
    wr(4'd6, colw);
  endtask

  initial begin
    for (int i = 0; i < NW; i++) model[i] = '0;
    #35 rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk(alert_n === 1'b0, "R1 alert after reset", alert_n, 0);
    all_check("R1 cleared words");

    // Table walk: R2 readback, R6 alert tracking, R7/R5 address handling
    for (int i = 0; i < 12; i++) begin
      wr(VEC[i][12:9], VEC[i][8:0]);
      chk(alert_n === model_alert_n(), "R6 alert after table write", alert_n, model_alert_n());
      rd_check(VEC[i][12:9], "R2 table readback");
    end
    all_check("R7 table end state");

    // R6: a consistent map lifts the alert immediately
    load_good(8'hA5, 8'h3C);
    chk(alert_n === 1'b1, "R6 good map clears alert", alert_n, 1);
    all_check("R2 good map readback");

    // R5: status write leaves alert high
    wr(4'd7, 9'h155);
    chk(alert_n === 1'b1, "R5 status write ignored by checks", alert_n, 1);
    rd_check(4'd7, "R5 status readback");

    // R7: unused writes change nothing
    wr(4'd8, 9'h1FF);
    wr(4'd12, 9'h0AA);
    chk(alert_n === 1'b1, "R7 unused write no alert change", alert_n, 1);
    all_check("R7 unused write no store change");

    // R3/R8: single flipped bit in word 3 -> row and column fail; stored as written
    wr(4'd3, model[3] ^ 9'h010);
    chk(alert_n === 1'b0, "R3 row error alert", alert_n, 0);
    rd_check(4'd3, "R8 bad word stored verbatim");

    // Repair
    wr(4'd3, model[3] ^ 9'h010);
    chk(alert_n === 1'b1, "R6 repair clears alert", alert_n, 1);

    // R4: two bits flipped in word 1 -> row still odd, two columns fail
    wr(4'd1, model[1] ^ 9'h006);
    chk(alert_n === 1'b0, "R4 column-only error alert", alert_n, 0);
    rd_check(4'd1, "R8 column-bad word stored verbatim");
    wr(4'd1, model[1] ^ 9'h006);
    chk(alert_n === 1'b1, "R4 column repair", alert_n, 1);

    // R4: word 6 has no row check, only its column role matters
    wr(4'd6, model[6] ^ 9'h001);
    chk(alert_n === 1'b0, "R4 column-check bit0 error", alert_n, 0);
    wr(4'd6, model[6] ^ 9'h001);
    chk(alert_n === 1'b1, "R4 column-check restored", alert_n, 1);

    // Second map pattern
    load_good(8'h00, 8'hFF);
    chk(alert_n === 1'b1, "R6 second good map", alert_n, 1);

    // R1: reset again clears everything
    @(negedge clk); rst_n = 0;
    for (int i = 0; i < NW; i++) model[i] = '0;
    #5;
    chk(alert_n === 1'b0, "R1 alert in reset", alert_n, 0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    all_check("R1 second reset cleared");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule